// File: doc/BRIEF.md
# Dual-Key Register Unlock Guard

This block protects two control registers of a memory controller against stray writes. Each register has a lock flag in bit 0 that is set at reset. The lock is cleared only when software writes an exact ordered pair of 32-bit magic words to a key register dedicated to that control register. The main control register and the option control register each have their own key register and their own lock. The two locks do not affect each other.

While a lock is set, writes to the other bits of its control register are dropped. Software can set a lock again at any time by writing 1 to bit 0 of the control register. Any misuse of a key register puts that channel into a fault state. Misuse means a wrong first word, a wrong second word, or a key write while the channel is already open. In the fault state the lock is forced on and stays on until reset. Software should therefore read the lock flag before it writes keys. Register reads are combinational from a separate read address.

Top module: `lock_guard_top`

## Requirements
- R1: After reset, bit 0 of the main control register (offset 0x0C) and bit 0 of the option control register (offset 0x18) both read 1, and their upper fields read 0.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the main key register (offset 0x04) clears the main lock, so bit 0 of offset 0x0C reads 0 in the cycle after the second write.
- R3: Writing 0x08192A3B and then 0x4C5D6E7F to the option key register (offset 0x08) clears the option lock, so bit 0 of offset 0x18 reads 0.
- R4: Key writes to one key register never change the lock of the other channel.
- R5: While a lock is set, a write to its control register leaves bits 31:1 of that register unchanged.
- R6: While a lock is clear, a write to its control register stores bits 31:1 of the write data, and a read returns them.
- R7: Writing a word with bit 0 set to a control register sets its lock. Writing 0 to bit 0 never clears a lock.
- R8: A first key word that is wrong, including the second key sent first, faults the channel. A later correct pair then leaves the lock set.
- R9: A correct first key followed by a wrong second word faults the channel, and the lock stays set.
- R10: A key write while the channel is unlocked sets the lock and faults the channel, so a later correct pair leaves it locked.
- R11: Both key registers always read as zero.
- R12: Reset clears a fault, after which the correct pair unlocks the channel again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| main_fields | output | 31 | Bits 31:1 of the main control register |
| opt_fields | output | 31 | Bits 31:1 of the option control register |

## Verification
The unlock path is tried with several key patterns: the correct pair, a wrong first word, the two keys in swapped order, and a correct first word followed by a wrong second word. Only the first pattern may open the lock. The other patterns show that both the value and the order of the words are checked. A key write to an already open channel shows that the fault also catches misuse after a good unlock. Writing one channel's keys to the other key register, and sending keys to one channel while watching the other, shows that the two channels are independent. Writes to the control registers are made while locked and while unlocked, with bit 0 both set and clear. These separate the write gating from the relock path.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;

    localparam int NUM_CH = 2;
    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Per-channel unlock sequencer state
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2,
        KS_FAULT  = 2'd3
    } key_state_e;

    // Channel 0: main control, channel 1: option control
    function automatic word_t key_first(input int ch);
        return (ch == 0) ? 32'h4567_0123 : 32'h0819_2A3B;
    endfunction

    function automatic word_t key_second(input int ch);
        return (ch == 0) ? 32'hCDEF_89AB : 32'h4C5D_6E7F;
    endfunction

    function automatic int key_offset(input int ch);
        return (ch == 0) ? 32'h04 : 32'h08;
    endfunction

    function automatic int ctrl_offset(input int ch);
        return (ch == 0) ? 32'h0C : 32'h18;
    endfunction

endpackage

// File: rtl/key_lock_seq.sv
module key_lock_seq
    import lock_guard_pkg::*;
#(
    parameter word_t KEY_A = 32'h0,
    parameter word_t KEY_B = 32'h0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  key_wr,
    input  word_t key_data,
    input  logic  relock,
    output logic  locked
);

    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_LOCKED: if (key_wr) state_d = (key_data == KEY_A) ? KS_HALF : KS_FAULT;
            KS_HALF: begin
                if (key_wr)      state_d = (key_data == KEY_B) ? KS_OPEN : KS_FAULT;
                else if (relock) state_d = KS_LOCKED;
            end
            KS_OPEN: begin
                if (key_wr)      state_d = KS_FAULT;
                else if (relock) state_d = KS_LOCKED;
            end
            KS_FAULT: state_d = KS_FAULT;
            default:  state_d = KS_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KS_LOCKED;
        else     state_q <= state_d;
    end

    assign locked = (state_q != KS_OPEN);

endmodule

// File: rtl/guarded_fields.sv
module guarded_fields #(
    parameter int FW = 31
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          locked,
    input  logic [FW-1:0] wdata,
    output logic [FW-1:0] fields
);

    always_ff @(posedge clk) begin
        if (rst)               fields <= '0;
        else if (wr && !locked) fields <= wdata;
    end

endmodule

// File: rtl/lock_guard_top.sv
module lock_guard_top
    import lock_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CTRL_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [CTRL_W-2:0] main_fields,
    output logic [CTRL_W-2:0] opt_fields
);

    localparam int FW = CTRL_W - 1;

    logic [NUM_CH-1:0] lock_vec;
    logic [FW-1:0]     fields [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : gen_chan
        logic key_hit;
        logic ctrl_hit;

        assign key_hit  = wr_en && (wr_addr == ADDR_W'(key_offset(ch)));
        assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(ctrl_offset(ch)));

        key_lock_seq #(
            .KEY_A(key_first(ch)),
            .KEY_B(key_second(ch))
        ) u_seq (
            .clk     (clk),
            .rst     (rst),
            .key_wr  (key_hit),
            .key_data(wr_data),
            .relock  (ctrl_hit && wr_data[0]),
            .locked  (lock_vec[ch])
        );

        guarded_fields #(.FW(FW)) u_fields (
            .clk   (clk),
            .rst   (rst),
            .wr    (ctrl_hit),
            .locked(lock_vec[ch]),
            .wdata (wr_data[CTRL_W-1:1]),
            .fields(fields[ch])
        );
    end

    // Key registers fall through to the zero default
    always_comb begin
        rd_data = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (rd_addr == ADDR_W'(ctrl_offset(ch)))
                rd_data = WORD_W'({fields[ch], lock_vec[ch]});
        end
    end

    assign main_fields = fields[0];
    assign opt_fields  = fields[1];

endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk
    import lock_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CTRL_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WORD_W-1:0] rd_data,
    input logic              main_lock,
    input logic              opt_lock,
    input logic [CTRL_W-2:0] main_fields
);

    localparam logic [ADDR_W-1:0] MKEY  = ADDR_W'(key_offset(0));
    localparam logic [ADDR_W-1:0] OKEY  = ADDR_W'(key_offset(1));
    localparam logic [ADDR_W-1:0] MCTRL = ADDR_W'(ctrl_offset(0));

    assert_reset_locked_R1: assert property (@(posedge clk)
        rst |=> (main_lock && opt_lock));

    assert_main_unlock_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(main_lock) |-> $past(wr_en && wr_addr == MKEY && wr_data == key_second(0)));

    assert_opt_unlock_cause_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(opt_lock) |-> $past(wr_en && wr_addr == OKEY && wr_data == key_second(1)));

    assert_channel_indep_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == MKEY) |=> $stable(opt_lock));

    assert_locked_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (main_lock && wr_en && wr_addr == MCTRL) |=> $stable(main_fields));

    assert_relock_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == MCTRL && wr_data[0]) |=> main_lock);

    assert_key_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == MKEY || rd_addr == OKEY) |-> (rd_data == '0));

endmodule

bind lock_guard_top lock_guard_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .main_lock  (lock_vec[0]),
    .opt_lock   (lock_vec[1]),
    .main_fields(main_fields)
);

// File: tb/test_lock_guard_top.sv
module test_lock_guard_top;

    localparam logic [7:0]  MKEY  = 8'h04;
    localparam logic [7:0]  OKEY  = 8'h08;
    localparam logic [7:0]  MCTRL = 8'h0C;
    localparam logic [7:0]  OCTRL = 8'h18;
    localparam logic [31:0] MK1 = 32'h4567_0123, MK2 = 32'hCDEF_89AB;
    localparam logic [31:0] OK1 = 32'h0819_2A3B, OK2 = 32'h4C5D_6E7F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [30:0] main_fields, opt_fields;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    lock_guard_top i_lock_guard_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .main_fields(main_fields), .opt_fields(opt_fields)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr_en = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        bus_read(MCTRL, v); check("R1 main ctrl", v, 32'h1);
        bus_read(OCTRL, v); check("R1 opt ctrl", v, 32'h1);
    endtask

    task automatic t_main_unlock();
        logic [31:0] v;
        do_reset();
        bus_write(MKEY, MK1); bus_write(MKEY, MK2);
        bus_read(MCTRL, v); check("R2 main unlocked", v, 32'h0);
        bus_read(OCTRL, v); check("R4 opt still locked", v, 32'h1);
        bus_write(MCTRL, 32'hA5A5_5A5A);
        bus_read(MCTRL, v); check("R6 fields stored", v, 32'hA5A5_5A5A);
        check("R6 main_fields port", {1'b0, main_fields}, 32'h52D2_AD2D);
        bus_write(MCTRL, 32'h0F0F_0001);
        bus_read(MCTRL, v); check("R7 relock with data", v, 32'h0F0F_0001);
        bus_write(MCTRL, 32'h1234_5678);
        bus_read(MCTRL, v); check("R5 locked write dropped", v, 32'h0F0F_0001);
        check("R7 zero bit0 no unlock", v & 32'h1, 32'h1);
    endtask

    task automatic t_opt_unlock();
        logic [31:0] v;
        do_reset();
        bus_write(OKEY, OK1); bus_write(OKEY, OK2);
        bus_read(OCTRL, v); check("R3 opt unlocked", v, 32'h0);
        bus_read(MCTRL, v); check("R4 main still locked", v, 32'h1);
        bus_write(OCTRL, 32'h8000_0006);
        bus_read(OCTRL, v); check("R6 opt fields", v, 32'h8000_0006);
        bus_write(MCTRL, 32'hFFFF_FFFE);
        bus_read(MCTRL, v); check("R5 main locked write", v, 32'h1);
    endtask

    task automatic t_cross_keys();
        logic [31:0] v;
        do_reset();
        bus_write(MKEY, OK1); bus_write(MKEY, OK2);
        bus_read(MCTRL, v); check("R4 wrong channel keys", v, 32'h1);
        bus_write(OKEY, OK1); bus_write(OKEY, OK2);
        bus_read(OCTRL, v); check("R4 opt unaffected by main fault", v, 32'h0);
    endtask

    task automatic t_bad_first();
        logic [31:0] v;
        do_reset();
        bus_write(MKEY, MK2); bus_write(MKEY, MK1); bus_write(MKEY, MK2);
        bus_read(MCTRL, v); check("R8 swapped order faults", v, 32'h1);
        do_reset();
        bus_write(OKEY, 32'h0000_0000);
        bus_write(OKEY, OK1); bus_write(OKEY, OK2);
        bus_read(OCTRL, v); check("R8 wrong first word faults", v, 32'h1);
    endtask

    task automatic t_bad_second();
        logic [31:0] v;
        do_reset();
        bus_write(MKEY, MK1); bus_write(MKEY, MK1);
        bus_read(MCTRL, v); check("R9 wrong second word", v, 32'h1);
        bus_write(MKEY, MK1); bus_write(MKEY, MK2);
        bus_read(MCTRL, v); check("R9 stays faulted", v, 32'h1);
    endtask

    task automatic t_key_while_open();
        logic [31:0] v;
        do_reset();
        bus_write(MKEY, MK1); bus_write(MKEY, MK2);
        bus_write(MKEY, MK1);
        bus_read(MCTRL, v); check("R10 key while open relocks", v, 32'h1);
        bus_write(MKEY, MK1); bus_write(MKEY, MK2);
        bus_read(MCTRL, v); check("R10 fault blocks unlock", v, 32'h1);
        do_reset();
        bus_write(MKEY, MK1); bus_write(MKEY, MK2);
        bus_read(MCTRL, v); check("R12 reset clears fault", v, 32'h0);
    endtask

    task automatic t_key_readback();
        logic [31:0] v;
        bus_write(OKEY, OK1);
        bus_read(MKEY, v); check("R11 main key reads zero", v, 32'h0);
        bus_read(OKEY, v); check("R11 opt key reads zero", v, 32'h0);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_main_unlock();
                t_opt_unlock();
                t_cross_keys();
                t_bad_first();
                t_bad_second();
                t_key_while_open();
                t_key_readback();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule